// File: doc/BRIEF.md
# Bus Address Map Register File

This block translates an 18-bit device bus address into a 22-bit physical memory address through a table of 32 map entries. Each bus address is split into a 5-bit page number and a 13-bit offset, so each page covers 8 KB. The translation port is combinational: the page number selects an entry and the offset is added to it. The topmost page never uses the table. It always lands on a fixed I/O page base plus the offset.

Software programs the table through a register port. Each entry takes 4 bytes of register space. The low 16-bit word holds entry bits 15:0 and the high word holds entry bits 21:16. Both whole-word writes and single-byte writes are accepted. Bit 0 of every entry is held at zero, so each mapped base is word aligned. Register reads are combinational from the current register address.

Top module: `amap_regfile`

## Requirements
- R1: A synchronous reset clears every entry to zero, so all register reads return 0 and a page other than the top page translates to its bare offset.
- R2: The entry selected by the register port is reg_addr[6:2], so each entry occupies 4 byte addresses.
- R3: A read with reg_addr[1]=0 returns entry bits 15:0, and bit 0 of that value is always 0.
- R4: A read with reg_addr[1]=1 returns entry bits 21:16 in reg_rdata[5:0], and reg_rdata[15:6] reads as 0.
- R5: A word write (reg_we=1, reg_byte=0) replaces the 16-bit half chosen by reg_addr[1]. A write to the high half keeps only reg_wdata[5:0], and the other half is unchanged.
- R6: A byte write (reg_we=1, reg_byte=1) puts reg_wdata[7:0] into byte lane reg_addr[1:0] of the entry (bits 8·lane+7 down to 8·lane). Lane 2 keeps only its low 6 bits, and a write to lane 3 leaves the entry unchanged.
- R7: Every write clears entry bit 0, whatever the written data.
- R8: For a page number xl_bus_addr[17:13] below 31, xl_phys_addr equals entry[page] plus the offset xl_bus_addr[12:0], modulo 2^22.
- R9: For page 31, xl_phys_addr equals the I/O base 22'o17760000 plus the offset, whatever entry 31 holds. Entry 31 can still be read and written.
- R10: While reg_we is 0, no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_byte | input | 1 | 1 = byte write, 0 = word write |
| reg_addr | input | 7 | Register byte address: [6:2] entry, [1:0] lane/half |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| xl_bus_addr | input | 18 | Bus address to translate |
| xl_phys_addr | output | 22 | Translated physical address |

## Verification
The register port is driven with word writes to both halves of every entry, byte writes to all four lanes, and idle cycles that carry non-zero write data. This separates correct half and lane selection from writes that spill into a neighbouring field, and shows whether the write strobe is honoured. Translation is tried with the minimum and maximum offsets, with entries near the top of the 22-bit space so that the sum wraps, and on the top page after entry 31 has been loaded. This separates a correct bypass and truncation from using the table on the top page or carrying past bit 21. A long pseudo-random run then compares both outputs against a behavioural model on every cycle, and a mid-run reset checks that all entries clear.

// File: rtl/amap_pkg.sv
package amap_pkg;

    localparam int BUS_AW  = 18;
    localparam int PHYS_AW = 22;
    localparam int OFF_W   = 13;
    localparam int WORD_W  = 16;
    localparam logic [PHYS_AW-1:0] IO_BASE_DEF = 22'o17760000;

    typedef struct packed {
        logic              we;
        logic              byte_en;
        logic [1:0]        lane;
        logic [WORD_W-1:0] data;
    } wr_req_t;

    function automatic logic [31:0] field_mask(input logic byte_en, input logic [1:0] lane);
        if (byte_en)
            return 32'h0000_00FF << {lane, 3'b000};
        return 32'h0000_FFFF << {lane[1], 4'b0000};
    endfunction

endpackage

// File: rtl/amap_store.sv
module amap_store
    import amap_pkg::*;
#(
    parameter int PG_W    = 5,
    parameter int N_ENT   = 32,
    parameter int PHYS_AW = 22
) (
    input  logic                            clk,
    input  logic                            rst,
    input  wr_req_t                         req,
    input  logic [PG_W-1:0]                 idx,
    output logic [N_ENT-1:0][PHYS_AW-1:0]   ent
);

    logic [31:0]        old_w, mask_w, data_w, new_w;
    logic [PHYS_AW-1:0] next_ent;

    always_comb begin
        old_w  = 32'(ent[idx]);
        mask_w = field_mask(req.byte_en, req.lane);
        if (req.byte_en)
            data_w = {24'b0, req.data[7:0]} << {req.lane, 3'b000};
        else
            data_w = {16'b0, req.data} << {req.lane[1], 4'b0000};
        new_w    = (old_w & ~mask_w) | (data_w & mask_w);
        next_ent = new_w[PHYS_AW-1:0] & ~PHYS_AW'(1);
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ent[g] <= '0;
            else if (req.we && (idx == PG_W'(g)))
                ent[g] <= next_ent;
        end
    end

endmodule

// File: rtl/amap_rdmux.sv
module amap_rdmux #(
    parameter int PG_W    = 5,
    parameter int N_ENT   = 32,
    parameter int PHYS_AW = 22,
    parameter int WORD_W  = 16
) (
    input  logic [N_ENT-1:0][PHYS_AW-1:0] ent,
    input  logic [PG_W-1:0]               idx,
    input  logic                          hi_sel,
    output logic [WORD_W-1:0]             rdata
);

    localparam int HI_W = PHYS_AW - WORD_W;

    logic [PHYS_AW-1:0] sel;

    always_comb begin
        sel = ent[idx];
        if (hi_sel)
            rdata = WORD_W'(sel[PHYS_AW-1 -: HI_W]);
        else
            rdata = sel[WORD_W-1:0];
    end

endmodule

// File: rtl/amap_xlate.sv
module amap_xlate #(
    parameter int PG_W    = 5,
    parameter int N_ENT   = 32,
    parameter int BUS_AW  = 18,
    parameter int OFF_W   = 13,
    parameter int PHYS_AW = 22,
    parameter logic [PHYS_AW-1:0] IO_BASE = 22'o17760000
) (
    input  logic [N_ENT-1:0][PHYS_AW-1:0] ent,
    input  logic [BUS_AW-1:0]             bus_addr,
    output logic [PHYS_AW-1:0]            phys_addr
);

    logic [PG_W-1:0]    page;
    logic [OFF_W-1:0]   offset;
    logic [PHYS_AW-1:0] base;

    always_comb begin
        page      = bus_addr[BUS_AW-1:OFF_W];
        offset    = bus_addr[OFF_W-1:0];
        base      = (page == PG_W'(N_ENT - 1)) ? IO_BASE : ent[page];
        phys_addr = base + PHYS_AW'(offset);
    end

endmodule

// File: rtl/amap_regfile.sv
module amap_regfile
    import amap_pkg::*;
#(
    parameter int BUS_W   = amap_pkg::BUS_AW,
    parameter int PHYS_W  = amap_pkg::PHYS_AW,
    parameter int OFFS_W  = amap_pkg::OFF_W,
    parameter logic [PHYS_W-1:0] IO_BASE = amap_pkg::IO_BASE_DEF,
    localparam int PG_W   = BUS_W - OFFS_W,
    localparam int N_ENT  = 1 << PG_W,
    localparam int REG_AW = PG_W + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic                 reg_byte,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    input  logic [BUS_W-1:0]     xl_bus_addr,
    output logic [PHYS_W-1:0]    xl_phys_addr
);

    logic [N_ENT-1:0][PHYS_W-1:0] ent;
    logic [PG_W-1:0]              idx;
    wr_req_t                      req;

    always_comb begin
        idx         = reg_addr[REG_AW-1:2];
        req.we      = reg_we;
        req.byte_en = reg_byte;
        req.lane    = reg_addr[1:0];
        req.data    = reg_wdata;
    end

    amap_store #(.PG_W(PG_W), .N_ENT(N_ENT), .PHYS_AW(PHYS_W)) u_store (
        .clk(clk), .rst(rst), .req(req), .idx(idx), .ent(ent)
    );

    amap_rdmux #(.PG_W(PG_W), .N_ENT(N_ENT), .PHYS_AW(PHYS_W), .WORD_W(WORD_W)) u_rd (
        .ent(ent), .idx(idx), .hi_sel(reg_addr[1]), .rdata(reg_rdata)
    );

    amap_xlate #(.PG_W(PG_W), .N_ENT(N_ENT), .BUS_AW(BUS_W), .OFF_W(OFFS_W),
                 .PHYS_AW(PHYS_W), .IO_BASE(IO_BASE)) u_xl (
        .ent(ent), .bus_addr(xl_bus_addr), .phys_addr(xl_phys_addr)
    );

endmodule

// File: rtl/amap_checker.sv
module amap_checker #(
    parameter int BUS_W  = 18,
    parameter int PHYS_W = 22,
    parameter int OFFS_W = 13,
    parameter logic [PHYS_W-1:0] IO_BASE = 22'o17760000,
    parameter int REG_AW = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic              reg_byte,
    input logic [REG_AW-1:0] reg_addr,
    input logic [15:0]       reg_wdata,
    input logic [15:0]       reg_rdata,
    input logic [BUS_W-1:0]  xl_bus_addr,
    input logic [PHYS_W-1:0] xl_phys_addr
);

    localparam int PG_W = BUS_W - OFFS_W;

    assert_lo_bit0_R3: assert property (@(posedge clk) disable iff (rst)
        !reg_addr[1] |-> !reg_rdata[0]);

    assert_hi_zero_R4: assert property (@(posedge clk) disable iff (rst)
        reg_addr[1] |-> (reg_rdata[15:6] == '0));

    assert_word_lo_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_we) && !$past(reg_byte) && !$past(reg_addr[1])
         && (reg_addr == $past(reg_addr)))
        |-> (reg_rdata == {$past(reg_wdata[15:1]), 1'b0}));

    assert_word_hi_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_we) && !$past(reg_byte) && $past(reg_addr[1])
         && (reg_addr == $past(reg_addr)))
        |-> (reg_rdata == {10'b0, $past(reg_wdata[5:0])}));

    assert_io_page_R9: assert property (@(posedge clk) disable iff (rst)
        (xl_bus_addr[BUS_W-1:OFFS_W] == {PG_W{1'b1}})
        |-> (xl_phys_addr == IO_BASE + PHYS_W'(xl_bus_addr[OFFS_W-1:0])));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(reg_we) && $stable(reg_addr) && $stable(xl_bus_addr))
        |-> ($stable(reg_rdata) && $stable(xl_phys_addr)));

endmodule

bind amap_regfile amap_checker #(
    .BUS_W(BUS_W), .PHYS_W(PHYS_W), .OFFS_W(OFFS_W), .IO_BASE(IO_BASE), .REG_AW(REG_AW)
) u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_byte(reg_byte), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xl_bus_addr(xl_bus_addr),
    .xl_phys_addr(xl_phys_addr)
);

// File: tb/tb_amap_regfile.sv
module tb_amap_regfile;

    localparam longint PMASK = 64'h3F_FFFF;
    localparam longint IOB   = 64'h3F_E000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_byte = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [17:0] xl_bus_addr = '0;
    logic [21:0] xl_phys_addr;

    int tests = 0;
    int fails = 0;
    longint model [32];
    int unsigned seed = 32'h1234_5678;

    always #2 clk = ~clk;

    amap_regfile dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_byte(reg_byte), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xl_bus_addr(xl_bus_addr),
        .xl_phys_addr(xl_phys_addr)
    );

    function automatic longint exp_rd(input int a);
        longint e = model[(a >> 2) & 31];
        if ((a & 2) != 0) return (e >> 16) & 63;
        return e & 16'hFFFF;
    endfunction

    function automatic longint exp_xl(input int ba);
        int pg = (ba >> 13) & 31;
        longint off = ba & 8191;
        if (pg == 31) return (IOB + off) & PMASK;
        return (model[pg] + off) & PMASK;
    endfunction

    task automatic model_wr(input bit bt, input int a, input int d);
        int     i = (a >> 2) & 31;
        longint sc, m;
        if (bt) begin
            sc = 8 * (a & 3);
            m  = 64'hFF << sc;
            model[i] = (model[i] & ~m) | ((longint'(d & 255)) << sc);
        end else begin
            sc = 16 * ((a >> 1) & 1);
            m  = 64'hFFFF << sc;
            model[i] = (model[i] & ~m) | ((longint'(d & 65535)) << sc);
        end
        model[i] = model[i] & 64'h3F_FFFE;
    endtask

    task automatic check(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input bit we, input bit bt, input int a, input int d,
                        input int ba, input string tag);
        @(negedge clk);
        reg_we = we; reg_byte = bt; reg_addr = 7'(a); reg_wdata = 16'(d);
        xl_bus_addr = 18'(ba);
        #1;
        check({tag, " rdata"}, longint'(reg_rdata), exp_rd(a & 127));
        check({tag, " phys"},  longint'(xl_phys_addr), exp_xl(ba & 18'h3FFFF));
        @(posedge clk);
        if (we) model_wr(bt, a & 127, d & 16'hFFFF);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; reg_we = 1'b0;
        @(posedge clk);
        @(posedge clk);
        for (int i = 0; i < 32; i++) model[i] = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed >> 8);
    endfunction

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1: all entries zero after reset; translation is the bare offset
        for (int i = 0; i < 32; i++) begin
            step(0, 0, i * 4, 0, (i << 13) | 5, "R1 reset lo");
            step(0, 0, i * 4 + 2, 0, (i << 13) | 8191, "R1 reset hi");
        end
        // R2 R5 R7: word writes with odd data to both halves of every entry
        for (int i = 0; i < 32; i++) begin
            step(1, 0, i * 4, 16'h1001 + i * 16'h0203, 0, "R5 R7 word lo write");
            step(1, 0, i * 4 + 2, 16'hFFC0 | i, 0, "R5 word hi write");
        end
        for (int i = 0; i < 32; i++) begin
            step(0, 0, i * 4, 16'hBEEF, (i << 13), "R2 R3 read lo");
            step(0, 0, i * 4 + 2, 16'hBEEF, (i << 13) | 8191, "R4 R8 read hi");
        end
        // R8: wrap past 2^22
        step(1, 0, 5 * 4, 16'hFFFF, 0, "R8 set lo");
        step(1, 0, 5 * 4 + 2, 16'h003F, 0, "R8 set hi");
        step(0, 0, 5 * 4, 0, (5 << 13) | 8191, "R8 wrap");
        step(0, 0, 5 * 4, 0, (5 << 13) | 2, "R8 wrap small");
        // R6: byte writes into each lane, including lane 3
        for (int ln = 0; ln < 4; ln++) begin
            step(1, 1, 7 * 4 + ln, 16'hA5C3 + ln, 0, "R6 byte write");
            step(0, 0, 7 * 4, 0, 7 << 13, "R6 byte lo check");
            step(0, 0, 7 * 4 + 2, 0, 7 << 13, "R6 byte hi check");
        end
        // R9: entry 31 loaded, top page still hits the I/O base
        step(1, 0, 31 * 4, 16'h1234, 0, "R9 write e31");
        step(0, 0, 31 * 4, 0, (31 << 13), "R9 io page zero off");
        step(0, 0, 31 * 4, 0, (31 << 13) | 8191, "R9 io page max off");
        // R10: idle cycles with live data change nothing
        for (int i = 0; i < 8; i++)
            step(0, i & 1, i * 4, 16'hFFFF, (i << 13) | 1, "R10 no write");
        for (int i = 0; i < 8; i++)
            step(0, 0, i * 4 + 2, 0, (i << 13) | 3, "R10 still held");
        // pseudo-random traffic against the model
        for (int n = 0; n < 600; n++) begin
            int r = rnd();
            step(r[0] & r[3], r[1], rnd() & 127, rnd() & 16'hFFFF, rnd() & 18'h3FFFF,
                 "R2 R5 R6 R8 random");
        end
        // R1: reset mid-run clears everything
        do_reset();
        for (int i = 0; i < 32; i++)
            step(0, 0, i * 4 + ((i & 1) << 1), 0, (i << 13) | 100, "R1 mid reset");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule